// File: doc/BRIEF.md
# Stacked-Reference PWM Gate Generator for a Five-Switch-per-Leg Inverter

This block produces the fifteen gate signals for an inverter made of three legs, each leg a string of five series switches. With one switch of each leg off, that string feeds four three-phase loads from a single DC link. Every leg receives four signed reference samples, one per load, and they are stacked from highest to lowest. The samples are compared with one triangular carrier that all legs share. The number of samples above the carrier selects which switch of the string is off, so four of the five switches conduct at any steady moment.

New reference samples are taken only at the peak and the valley of the carrier. Each latched set is checked for correct stacking. A set that is out of order raises a fault and parks every leg in a safe zero state, with switch 1 off, until a correct set is latched. When the off position of a leg moves, the new switch is opened first and the previous one is closed again only after a programmable dead-time count. This prevents the whole string from conducting at once. A carrier half period of 50000 clocks gives a 2 kHz switching frequency at a 200 MHz clock.

Top module: `stk_pwm_top`

## Requirements
- R1: While rst_n is low, and until the first carrier turning point after release, every leg holds switch 1 off and switches 2 to 5 on. That is gate_o = 15'h7BDE, and fault_o = 0. The internal reset is released on the second rising clock edge after rst_n rises.
- R2: The carrier is a counter that starts at 0 and steps by one each clock. It runs up to CAR_TOP, then down to 0, then up again, so one carrier period is 2*CAR_TOP clocks. The signed carrier value is the counter value minus CAR_TOP/2.
- R3: References are latched only on the clock in which the counter stands at 0 or at CAR_TOP. A change on ref_i at any other time has no effect on the gates before the next turning point.
- R4: Let k be the number of the leg's four latched references that are strictly greater than the carrier. The off switch of the leg is then switch k+1. The gate of leg l, switch s (s = 1..5) is gate_o[5*l + s-1], with 1 meaning on. Reference n of leg l (n = 1..4, with 1 the highest) is ref_i[12*(4*l + n-1) +: 12] in two's complement. The gates follow the carrier value of the previous clock.
- R5: A latched set in which any leg has reference n below reference n+1 sets fault_o. Equal neighbours are valid. While fault_o is 1, every leg targets switch 1 off. fault_o is updated only at turning points.
- R6: When the target off switch of a leg changes and dead_i = D > 0, the new switch turns off on the next clock. The previously off switch stays off for D clocks and then turns on. With D = 0 the change is a plain swap.
- R7: No leg ever has all five switches on, and no leg ever has fewer than three on.
- R8: Each leg's off position depends only on that leg's own four references.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_i | input | 144 | Twelve signed 12-bit references, four per leg, packed per R4 |
| dead_i | input | 8 | Dead-time length in clocks |
| gate_o | output | 15 | Gate commands, five per leg, 1 = switch on |
| fault_o | output | 1 | Latched reference set was out of order |

## Verification
Two pairs of functions can act in the same clock. A reference latch at a carrier turning point can coincide with a move of the off position. A dead-time window can also be open when the target moves. The bench changes references in mid-ramp and checks that the gates still follow the old set up to the peak, then follow the new set on the falling ramp. It also starts a dead window on references that all sit at one value, so that the off position jumps from switch 5 to switch 1. The bench reads the doubled-off gate pattern on each clock of the window and a single-off pattern once it closes, while a monitor confirms on every clock that no leg ever has five switches on.

// File: rtl/stk_pwm_pkg.sv
package stk_pwm_pkg;
  parameter int unsigned LEGS  = 3;
  parameter int unsigned REFS  = 4;
  parameter int unsigned SWS   = REFS + 1;
  parameter int unsigned IDX_W = $clog2(SWS);

  typedef logic [IDX_W-1:0] sw_idx_t;

  // one bit set at the position of the open switch
  function automatic logic [SWS-1:0] off_mask(sw_idx_t idx);
    logic [SWS-1:0] m;
    for (int j = 0; j < SWS; j++) m[j] = (sw_idx_t'(j) == idx);
    return m;
  endfunction
endpackage

// File: rtl/stk_carrier.sv
module stk_carrier #(
  parameter int unsigned CAR_TOP = 50000,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned CAR_W   = 17
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic signed [CAR_W-1:0] car_o,
  output logic                    turn_o
);
  localparam logic [CNT_W-1:0] TOP_V  = CNT_W'(CAR_TOP);
  localparam logic [CNT_W-1:0] HALF_V = CNT_W'(CAR_TOP / 2);

  logic [CNT_W-1:0] cnt, cnt_n;
  logic             up, up_n;

  always_comb begin
    cnt_n = cnt;
    up_n  = up;
    if (up) begin
      if (cnt == TOP_V) begin
        cnt_n = TOP_V - CNT_W'(1);
        up_n  = 1'b0;
      end else begin
        cnt_n = cnt + CNT_W'(1);
      end
    end else begin
      if (cnt == '0) begin
        cnt_n = CNT_W'(1);
        up_n  = 1'b1;
      end else begin
        cnt_n = cnt - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      up  <= 1'b1;
    end else begin
      cnt <= cnt_n;
      up  <= up_n;
    end
  end

  assign turn_o = (cnt == '0) || (cnt == TOP_V);
  assign car_o  = $signed({1'b0, cnt}) - $signed({1'b0, HALF_V});

  a_r2_bounds: assert property (@(posedge clk) disable iff (!rst_n) cnt <= TOP_V);
  a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (({1'b0, cnt} == {1'b0, $past(cnt)} + 1'b1) ||
              ({1'b0, cnt} + 1'b1 == {1'b0, $past(cnt)})));
endmodule

// File: rtl/stk_ref_latch.sv
module stk_ref_latch
  import stk_pwm_pkg::*;
#(
  parameter int unsigned REF_W = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        turn_i,
  input  logic [LEGS*REFS*REF_W-1:0]  ref_i,
  output logic [LEGS*REFS*REF_W-1:0]  lat_o,
  output logic                        fault_o
);
  localparam int unsigned   TOT     = LEGS * REFS * REF_W;
  localparam logic [REF_W-1:0] MIN_REF = {1'b1, {(REF_W-1){1'b0}}};

  logic [LEGS-1:0] bad_leg;
  logic [TOT-1:0]  lat_n;
  logic            fault_n;

  for (genvar l = 0; l < LEGS; l++) begin : g_leg
    logic [REFS-2:0] inv;
    for (genvar r = 0; r < REFS - 1; r++) begin : g_pair
      assign inv[r] = $signed(ref_i[(l*REFS + r)*REF_W +: REF_W]) <
                      $signed(ref_i[(l*REFS + r + 1)*REF_W +: REF_W]);
    end
    assign bad_leg[l] = |inv;
  end

  always_comb begin
    lat_n   = lat_o;
    fault_n = fault_o;
    if (turn_i) begin
      lat_n   = ref_i;
      fault_n = |bad_leg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_o   <= {(LEGS*REFS){MIN_REF}};
      fault_o <= 1'b0;
    end else begin
      lat_o   <= lat_n;
      fault_o <= fault_n;
    end
  end

  a_r3_hold_refs: assert property (@(posedge clk) disable iff (!rst_n)
    !turn_i |=> $stable(lat_o));
  a_r5_hold_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !turn_i |=> $stable(fault_o));
endmodule

// File: rtl/stk_leg_seq.sv
module stk_leg_seq
  import stk_pwm_pkg::*;
#(
  parameter int unsigned REF_W = 12,
  parameter int unsigned CAR_W = 17,
  parameter int unsigned DT_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [REFS*REF_W-1:0]   ref_i,
  input  logic signed [CAR_W-1:0] car_i,
  input  logic                    safe_i,
  input  logic [DT_W-1:0]         dead_i,
  output logic [SWS-1:0]          gate_o
);
  localparam int unsigned CMP_W = ((REF_W > CAR_W) ? REF_W : CAR_W) + 1;
  localparam int unsigned K_W   = $clog2(REFS + 1);

  logic [REFS-1:0]         above;
  logic signed [CMP_W-1:0] car_x;
  logic [K_W-1:0]          k;
  sw_idx_t                 tgt;

  assign car_x = {{(CMP_W-CAR_W){car_i[CAR_W-1]}}, car_i};

  for (genvar r = 0; r < REFS; r++) begin : g_cmp
    logic signed [CMP_W-1:0] ref_x;
    assign ref_x    = {{(CMP_W-REF_W){ref_i[r*REF_W + REF_W-1]}}, ref_i[r*REF_W +: REF_W]};
    assign above[r] = ref_x > car_x;
  end

  always_comb begin
    k = '0;
    for (int r = 0; r < REFS; r++) k = k + K_W'(above[r]);
    tgt = safe_i ? sw_idx_t'(0) : sw_idx_t'(k);
  end

  // off_now: switch just opened; off_old: switch kept open through dead time
  sw_idx_t         off_now, off_old, now_n, old_n;
  logic [DT_W-1:0] dt, dt_n;

  always_comb begin
    now_n = off_now;
    old_n = off_old;
    dt_n  = dt;
    if (tgt != off_now) begin
      now_n = tgt;
      if (dead_i == '0) begin
        old_n = tgt;
        dt_n  = '0;
      end else begin
        old_n = off_now;
        dt_n  = dead_i;
      end
    end else if (dt != '0) begin
      dt_n = dt - DT_W'(1);
      if (dt == DT_W'(1)) old_n = off_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_now <= '0;
      off_old <= '0;
      dt      <= '0;
    end else begin
      off_now <= now_n;
      off_old <= old_n;
      dt      <= dt_n;
    end
  end

  assign gate_o = ~(off_mask(off_now) | off_mask(off_old));

  a_r7_on_count: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(gate_o) <= SWS - 1) && ($countones(gate_o) >= SWS - 2));
  a_r6_new_opens_first: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt != off_now) |=> !gate_o[$past(tgt)]);
  a_r6_old_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((tgt != off_now) && (dead_i != '0)) |=> !gate_o[$past(off_now)]);
  a_r4_single_off: assert property (@(posedge clk) disable iff (!rst_n)
    ((tgt == off_now) && (dt == '0)) |=> ($countones(gate_o) == SWS - 1));
endmodule

// File: rtl/stk_pwm_top.sv
module stk_pwm_top
  import stk_pwm_pkg::*;
#(
  parameter int unsigned REF_W   = 12,
  parameter int unsigned CAR_TOP = 50000,
  parameter int unsigned DT_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [LEGS*REFS*REF_W-1:0] ref_i,
  input  logic [DT_W-1:0]            dead_i,
  output logic [LEGS*SWS-1:0]        gate_o,
  output logic                       fault_o
);
  localparam int unsigned CNT_W = $clog2(CAR_TOP + 1);
  localparam int unsigned CAR_W = CNT_W + 1;

  logic [1:0] rst_sync;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  logic signed [CAR_W-1:0]   car;
  logic                      turn;
  logic [LEGS*REFS*REF_W-1:0] lat;

  stk_carrier #(.CAR_TOP(CAR_TOP), .CNT_W(CNT_W), .CAR_W(CAR_W)) u_car (
    .clk(clk), .rst_n(rst_core_n), .car_o(car), .turn_o(turn));

  stk_ref_latch #(.REF_W(REF_W)) u_lat (
    .clk(clk), .rst_n(rst_core_n), .turn_i(turn), .ref_i(ref_i),
    .lat_o(lat), .fault_o(fault_o));

  for (genvar l = 0; l < LEGS; l++) begin : g_leg
    stk_leg_seq #(.REF_W(REF_W), .CAR_W(CAR_W), .DT_W(DT_W)) u_seq (
      .clk(clk), .rst_n(rst_core_n),
      .ref_i(lat[l*REFS*REF_W +: REFS*REF_W]),
      .car_i(car), .safe_i(fault_o), .dead_i(dead_i),
      .gate_o(gate_o[l*SWS +: SWS]));
  end
endmodule

// File: tb/stk_pwm_top_tb_top.sv
`timescale 1ns/1ps
module stk_pwm_top_tb_top;
  localparam int TOP  = 16;
  localparam int HALF = TOP / 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [143:0] ref_flat = '0;
  logic [7:0]   dead = '0;
  logic [14:0]  gate_o;
  logic         fault_o;

  always #2.5 clk = ~clk;

  stk_pwm_top #(.REF_W(12), .CAR_TOP(TOP), .DT_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_i(ref_flat), .dead_i(dead),
    .gate_o(gate_o), .fault_o(fault_o));

  int n_total = 0;
  int n_pass  = 0;
  int r7_bad  = 0;
  bit done    = 1'b0;

  // carrier timing model from R1/R2: bprev = counter value before the last edge
  logic s1, s2;
  int   bcnt, bprev;
  bit   bup;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; bcnt <= 0; bprev <= 0; bup <= 1'b1;
    end else begin
      s1 <= 1'b1; s2 <= s1; bprev <= bcnt;
      if (s2) begin
        if (bup) begin
          if (bcnt == TOP) begin bcnt <= TOP - 1; bup <= 1'b0; end
          else bcnt <= bcnt + 1;
        end else begin
          if (bcnt == 0) begin bcnt <= 1; bup <= 1'b1; end
          else bcnt <= bcnt - 1;
        end
      end
    end
  end

  // R7 monitor
  always @(negedge clk) begin
    if (rst_n) begin
      for (int l = 0; l < 3; l++) begin
        int c;
        c = $countones(gate_o[5*l +: 5]);
        if (c > 4 || c < 3) r7_bad++;
      end
    end
  end

  // {ref1, ref2, ref3, ref4, carrier value, expected off switch}
  localparam int VEC [0:7][0:5] = '{
    '{6, 3, 0, -3,  1, 3},
    '{6, 3, 0, -3, -4, 5},
    '{6, 3, 0, -3,  7, 1},
    '{4, 4, 4,  4,  4, 1},
    '{4, 4, 4,  4,  3, 5},
    '{8, 0, 0, -8,  8, 1},
    '{8, 0, 0, -8, -7, 4},
    '{2, 1, 1,  1,  1, 2}
  };

  function automatic logic [4:0] leg_gates(int off);
    return 5'h1F & ~(5'b1 << (off - 1));
  endfunction

  function automatic logic [14:0] all_gates(int o0, int o1, int o2);
    return {leg_gates(o2), leg_gates(o1), leg_gates(o0)};
  endfunction

  task automatic chk(bit ok, string what, logic [31:0] act, logic [31:0] exp);
    n_total++;
    if (ok) n_pass++;
    else $display("FAIL %s: actual %0h expected %0h", what, act, exp);
  endtask

  task automatic set_leg(int l, int a, int b, int c, int d);
    ref_flat[(4*l+0)*12 +: 12] = 12'(a);
    ref_flat[(4*l+1)*12 +: 12] = 12'(b);
    ref_flat[(4*l+2)*12 +: 12] = 12'(c);
    ref_flat[(4*l+3)*12 +: 12] = 12'(d);
  endtask

  task automatic set_all(int a, int b, int c, int d);
    for (int l = 0; l < 3; l++) set_leg(l, a, b, c, d);
  endtask

  task automatic wait_cnt(int v);
    do @(negedge clk); while (bprev != v);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_pass, n_total);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_total++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(gate_o == 15'h7BDE, "R1 gates in reset", 32'(gate_o), 32'h7BDE);
    chk(fault_o == 1'b0, "R1 fault in reset", 32'(fault_o), 0);
    rst_n = 1'b1;

    // R4 table walk, zero dead time; equal references must not fault (R5)
    for (int i = 0; i < 8; i++) begin
      set_all(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);
      wait_cnt(0);
      wait_cnt(VEC[i][4] + HALF);
      chk(gate_o == all_gates(VEC[i][5], VEC[i][5], VEC[i][5]),
          $sformatf("R4 vector %0d gates", i), 32'(gate_o),
          32'(all_gates(VEC[i][5], VEC[i][5], VEC[i][5])));
      chk(fault_o == 1'b0, $sformatf("R5 vector %0d no fault", i), 32'(fault_o), 0);
    end

    // R8 legs independent
    set_leg(0, 7, 7, 7, 7);
    set_leg(1, -7, -7, -7, -7);
    set_leg(2, 6, 2, -1, -5);
    wait_cnt(0);
    wait_cnt(HALF);
    chk(gate_o == all_gates(5, 1, 3), "R8 per-leg offs", 32'(gate_o), 32'(all_gates(5, 1, 3)));

    // R3 mid-ramp change ignored until the peak
    set_all(6, 3, 0, -3);
    wait_cnt(0);
    wait_cnt(2);
    set_all(-8, -8, -8, -8);
    wait_cnt(6);
    chk(gate_o == all_gates(4, 4, 4), "R3 old set kept mid-ramp", 32'(gate_o), 32'(all_gates(4, 4, 4)));
    wait_cnt(TOP);
    wait_cnt(TOP - 1);
    chk(gate_o == all_gates(1, 1, 1), "R3 new set after peak", 32'(gate_o), 32'(all_gates(1, 1, 1)));

    // R2 carrier period from successive entries into switch 1 off
    begin
      int n;
      set_all(0, 0, 0, 0);
      wait_cnt(0);
      do @(negedge clk); while (gate_o[4:0] != 5'b11110);
      n = 0;
      do begin @(negedge clk); n++; end while (gate_o[4:0] == 5'b11110);
      do begin @(negedge clk); n++; end while (gate_o[4:0] != 5'b11110);
      chk(n == 2 * TOP, "R2 carrier period", 32'(n), 32'(2 * TOP));
    end

    // R5 ordering fault and recovery
    set_leg(0, 6, 3, 0, -3);
    set_leg(1, 1, 2, 0, 0);
    set_leg(2, 6, 3, 0, -3);
    wait_cnt(0);
    chk(fault_o == 1'b1, "R5 fault raised", 32'(fault_o), 1);
    wait_cnt(4);
    chk(gate_o == 15'h7BDE, "R5 safe state", 32'(gate_o), 32'h7BDE);
    set_all(6, 3, 0, -3);
    wait_cnt(TOP);
    chk(fault_o == 1'b0, "R5 fault cleared", 32'(fault_o), 0);
    wait_cnt(13);
    chk(gate_o == all_gates(2, 2, 2), "R5 normal after clear", 32'(gate_o), 32'(all_gates(2, 2, 2)));

    // R6 dead time of 3 clocks, off jumps from switch 5 to switch 1
    dead = 8'd3;
    set_all(2, 2, 2, 2);
    wait_cnt(0);
    wait_cnt(HALF + 1);
    chk(gate_o == all_gates(5, 5, 5), "R6 before move", 32'(gate_o), 32'(all_gates(5, 5, 5)));
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk(gate_o == 15'b01110_01110_01110, $sformatf("R6 dead window clock %0d", j),
          32'(gate_o), 32'(15'b01110_01110_01110));
    end
    @(negedge clk);
    chk(gate_o == all_gates(1, 1, 1), "R6 old switch back on", 32'(gate_o), 32'(all_gates(1, 1, 1)));

    chk(r7_bad == 0, "R7 on-count monitor", 32'(r7_bad), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule